// File: doc/BRIEF.md
# Software Trap Entry and Interrupt Mask Controller

This block owns the status word, the two exception save registers and the cause register of a small processor core. When the core strobes a software trap with a 5-bit vector, the block records where to come back to and what the status word held. It writes an exception code into the cause register, marks the core as being in exception processing with interrupts masked, and hands the core a one-cycle redirect to a fixed handler address. The same block serves the instructions that mask and unmask interrupts.

Vector 31 is kept for a host-side service path. It takes no part in exception entry, so the block lets such a request fall through. The core's own system-register write path loads the status word and the cause register through two plain write strobes. Those writes are the lowest-priority update.

Top module: `trapc_top`

## Requirements
- R1: After reset the status word, both save registers, the cause register, the redirect valid and the redirect address are all zero.
- R2: A trap with vector 0..30 loads the saved return PC with the core PC plus 4 on the clock edge that samples the strobe. Without an accepted trap the saved return PC keeps its value.
- R3: An accepted trap loads the saved status register with the status word as it was before that edge. Without an accepted trap the saved status register keeps its value.
- R4: An accepted trap keeps cause bits 31:16 and sets cause bits 15:0 to 0x0040 plus the vector.
- R5: An accepted trap sets status bit 6 (exception in progress) and bit 5 (interrupts masked), and leaves all other status bits as they were.
- R6: The cycle after an accepted trap, the redirect valid is 1 for exactly one cycle unless another trap follows. The redirect address is 0x40 for vectors below 16 and 0x50 for vectors 16..30. Otherwise the redirect valid is 0.
- R7: A mask request sets status bit 5 and an unmask request clears it. Neither changes any other status bit, and neither raises the redirect.
- R8: A trap request with vector 31 is ignored. No register changes on its account and no redirect follows, while other requests in the same cycle act as if the trap strobe were low.
- R9: Priority in one cycle runs trap (vector 0..30) first, then mask, then unmask, then the status write. A cause write is dropped only when a trap is accepted.
- R10: A status write loads the whole status word and a cause write loads the whole cause register, each on the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req_i | input | 1 | One-cycle trap strobe |
| trap_vec_i | input | 5 | Trap vector |
| pc_i | input | 32 | PC of the trapping instruction |
| mask_req_i | input | 1 | Mask-interrupts strobe |
| unmask_req_i | input | 1 | Unmask-interrupts strobe |
| stat_wr_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 32 | Status word write data |
| cause_wr_i | input | 1 | Cause register write strobe |
| cause_wdata_i | input | 32 | Cause register write data |
| stat_o | output | 32 | Status word |
| save_pc_o | output | 32 | Saved return PC |
| save_stat_o | output | 32 | Saved status word |
| cause_o | output | 32 | Cause register |
| redir_vld_o | output | 1 | Redirect strobe |
| redir_pc_o | output | 32 | Redirect target |

## Verification
The assertions take every strobe to be a clean synchronous level sampled at one edge. They also take the PC to be free to carry any value, with the wrap of PC plus 4 allowed. They do not assume that requests are exclusive, because any mix of trap, mask, unmask and the two writes may arrive together. The stimulus drives all inputs only at the falling edge and draws the strobes independently from a seeded generator, so collisions occur often. Vectors are biased towards 15, 16, 30 and 31 so that the address split and the reserved vector are hit repeatedly.

// File: rtl/trapc_pkg.sv
package trapc_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_TRAP   = 2'd1,
    EV_MASK   = 2'd2,
    EV_UNMASK = 2'd3
  } trapc_ev_e;
endpackage

// File: rtl/trapc_arb.sv
module trapc_arb
  import trapc_pkg::*;
#(
  parameter int VEC_W    = 5,
  parameter int RSVD_VEC = 31
) (
  input  logic             trap_req_i,
  input  logic [VEC_W-1:0] trap_vec_i,
  input  logic             mask_req_i,
  input  logic             unmask_req_i,
  input  logic             stat_wr_i,
  input  logic             cause_wr_i,
  output trapc_ev_e        ev_o,
  output logic             stat_wr_ok_o,
  output logic             cause_wr_ok_o
);
  localparam logic [VEC_W-1:0] RSVD = VEC_W'(RSVD_VEC);

  logic trap_ok;

  always_comb begin
    trap_ok = trap_req_i && (trap_vec_i != RSVD);
    if (trap_ok)           ev_o = EV_TRAP;
    else if (mask_req_i)   ev_o = EV_MASK;
    else if (unmask_req_i) ev_o = EV_UNMASK;
    else                   ev_o = EV_NONE;
    stat_wr_ok_o  = stat_wr_i && (ev_o == EV_NONE);
    cause_wr_ok_o = cause_wr_i && !trap_ok;
  end
endmodule

// File: rtl/trapc_vector.sv
module trapc_vector #(
  parameter int XLEN      = 32,
  parameter int VEC_W     = 5,
  parameter int PC_STEP   = 4,
  parameter int CODE_BASE = 'h40,
  parameter int SPLIT_VEC = 16,
  parameter int LO_ADDR   = 'h40,
  parameter int HI_ADDR   = 'h50
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  cause_q_i,
  output logic [XLEN-1:0]  ret_pc_o,
  output logic [XLEN-1:0]  cause_trap_o,
  output logic [XLEN-1:0]  target_o
);
  localparam int HALF = XLEN / 2;
  localparam logic [HALF-1:0] BASE = HALF'(CODE_BASE);

  logic [HALF-1:0] code;

  always_comb begin
    ret_pc_o     = pc_i + XLEN'(PC_STEP);
    code         = BASE + HALF'(vec_i);
    cause_trap_o = {cause_q_i[XLEN-1:HALF], code};
  end

  generate
    if (SPLIT_VEC >= (1 << VEC_W)) begin : g_single
      assign target_o = XLEN'(LO_ADDR);
    end else begin : g_split
      assign target_o = (int'(vec_i) < SPLIT_VEC) ? XLEN'(LO_ADDR) : XLEN'(HI_ADDR);
    end
  endgenerate
endmodule

// File: rtl/trapc_stat_next.sv
module trapc_stat_next
  import trapc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int MSK_BIT = 5,
  parameter int EXC_BIT = 6
) (
  input  logic [XLEN-1:0] stat_q_i,
  input  trapc_ev_e       ev_i,
  input  logic            wr_ok_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] stat_d_o
);
  localparam logic [XLEN-1:0] MSK_M = XLEN'(1) << MSK_BIT;
  localparam logic [XLEN-1:0] EXC_M = XLEN'(1) << EXC_BIT;

  always_comb begin
    stat_d_o = stat_q_i;
    unique case (ev_i)
      EV_TRAP:   stat_d_o = stat_q_i | MSK_M | EXC_M;
      EV_MASK:   stat_d_o = stat_q_i | MSK_M;
      EV_UNMASK: stat_d_o = stat_q_i & ~MSK_M;
      default:   if (wr_ok_i) stat_d_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/trapc_top.sv
module trapc_top
  import trapc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_W     = 5,
  parameter int RSVD_VEC  = 31,
  parameter int PC_STEP   = 4,
  parameter int CODE_BASE = 'h40,
  parameter int SPLIT_VEC = 16,
  parameter int LO_ADDR   = 'h40,
  parameter int HI_ADDR   = 'h50,
  parameter int MSK_BIT   = 5,
  parameter int EXC_BIT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req_i,
  input  logic [VEC_W-1:0] trap_vec_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             mask_req_i,
  input  logic             unmask_req_i,
  input  logic             stat_wr_i,
  input  logic [XLEN-1:0]  stat_wdata_i,
  input  logic             cause_wr_i,
  input  logic [XLEN-1:0]  cause_wdata_i,
  output logic [XLEN-1:0]  stat_o,
  output logic [XLEN-1:0]  save_pc_o,
  output logic [XLEN-1:0]  save_stat_o,
  output logic [XLEN-1:0]  cause_o,
  output logic             redir_vld_o,
  output logic [XLEN-1:0]  redir_pc_o
);
  trapc_ev_e       ev;
  logic            stat_wr_ok, cause_wr_ok, trap_go;
  logic [XLEN-1:0] ret_pc, cause_trap, target;
  logic [XLEN-1:0] stat_q, stat_d, spc_q, spc_d, sst_q, sst_d;
  logic [XLEN-1:0] cause_q, cause_d, rpc_q, rpc_d;
  logic            rv_q, rv_d;
  logic            en_stat, en_save, en_cause, en_rpc;

  trapc_arb #(.VEC_W(VEC_W), .RSVD_VEC(RSVD_VEC)) arb_i (
    .trap_req_i(trap_req_i), .trap_vec_i(trap_vec_i),
    .mask_req_i(mask_req_i), .unmask_req_i(unmask_req_i),
    .stat_wr_i(stat_wr_i), .cause_wr_i(cause_wr_i),
    .ev_o(ev), .stat_wr_ok_o(stat_wr_ok), .cause_wr_ok_o(cause_wr_ok)
  );

  trapc_vector #(
    .XLEN(XLEN), .VEC_W(VEC_W), .PC_STEP(PC_STEP), .CODE_BASE(CODE_BASE),
    .SPLIT_VEC(SPLIT_VEC), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) vec_i (
    .pc_i(pc_i), .vec_i(trap_vec_i), .cause_q_i(cause_q),
    .ret_pc_o(ret_pc), .cause_trap_o(cause_trap), .target_o(target)
  );

  trapc_stat_next #(.XLEN(XLEN), .MSK_BIT(MSK_BIT), .EXC_BIT(EXC_BIT)) sn_i (
    .stat_q_i(stat_q), .ev_i(ev), .wr_ok_i(stat_wr_ok),
    .wdata_i(stat_wdata_i), .stat_d_o(stat_d)
  );

  // next-state
  always_comb begin
    trap_go  = (ev == EV_TRAP);
    en_stat  = (ev != EV_NONE) || stat_wr_ok;
    en_save  = trap_go;
    en_cause = trap_go || cause_wr_ok;
    en_rpc   = trap_go;
    spc_d    = ret_pc;
    sst_d    = stat_q;
    cause_d  = trap_go ? cause_trap : cause_wdata_i;
    rpc_d    = target;
    rv_d     = trap_go;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      spc_q   <= '0;
      sst_q   <= '0;
      cause_q <= '0;
      rpc_q   <= '0;
      rv_q    <= 1'b0;
    end else begin
      rv_q <= rv_d;
      if (en_stat)  stat_q  <= stat_d;
      if (en_save)  spc_q   <= spc_d;
      if (en_save)  sst_q   <= sst_d;
      if (en_cause) cause_q <= cause_d;
      if (en_rpc)   rpc_q   <= rpc_d;
    end
  end

  assign stat_o      = stat_q;
  assign save_pc_o   = spc_q;
  assign save_stat_o = sst_q;
  assign cause_o     = cause_q;
  assign redir_vld_o = rv_q;
  assign redir_pc_o  = rpc_q;
endmodule

// File: rtl/trapc_chk.sv
module trapc_chk #(
  parameter int XLEN      = 32,
  parameter int VEC_W     = 5,
  parameter int RSVD_VEC  = 31,
  parameter int PC_STEP   = 4,
  parameter int SPLIT_VEC = 16,
  parameter int LO_ADDR   = 'h40,
  parameter int HI_ADDR   = 'h50,
  parameter int MSK_BIT   = 5,
  parameter int EXC_BIT   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trap_req_i,
  input logic [VEC_W-1:0] trap_vec_i,
  input logic [XLEN-1:0]  pc_i,
  input logic             mask_req_i,
  input logic             unmask_req_i,
  input logic             stat_wr_i,
  input logic             cause_wr_i,
  input logic [XLEN-1:0]  stat_o,
  input logic [XLEN-1:0]  save_pc_o,
  input logic [XLEN-1:0]  cause_o,
  input logic             redir_vld_o,
  input logic [XLEN-1:0]  redir_pc_o
);
  logic acc, rsvd_only;
  assign acc       = trap_req_i && (trap_vec_i != VEC_W'(RSVD_VEC));
  assign rsvd_only = trap_req_i && !acc && !mask_req_i && !unmask_req_i
                     && !stat_wr_i && !cause_wr_i;

  a_r2_ret_pc: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> save_pc_o == $past(pc_i) + XLEN'(PC_STEP));

  a_r4_cause_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> cause_o[XLEN-1:XLEN/2] == $past(cause_o[XLEN-1:XLEN/2]));

  a_r5_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> stat_o[MSK_BIT] && stat_o[EXC_BIT]);

  a_r6_redir_cause: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> $past(acc));

  a_r6_redir_addr: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> redir_pc_o == ((int'($past(trap_vec_i)) < SPLIT_VEC) ? XLEN'(LO_ADDR) : XLEN'(HI_ADDR)));

  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_req_i && !acc) |=> stat_o[MSK_BIT]);

  a_r7_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_req_i && !mask_req_i && !acc) |=> !stat_o[MSK_BIT] && $stable(stat_o[EXC_BIT]));

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_only |=> $stable(stat_o) && $stable(cause_o) && $stable(save_pc_o) && !redir_vld_o);
endmodule

bind trapc_top trapc_chk #(
  .XLEN(XLEN), .VEC_W(VEC_W), .RSVD_VEC(RSVD_VEC), .PC_STEP(PC_STEP),
  .SPLIT_VEC(SPLIT_VEC), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR),
  .MSK_BIT(MSK_BIT), .EXC_BIT(EXC_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req_i), .trap_vec_i(trap_vec_i),
  .pc_i(pc_i), .mask_req_i(mask_req_i), .unmask_req_i(unmask_req_i),
  .stat_wr_i(stat_wr_i), .cause_wr_i(cause_wr_i), .stat_o(stat_o),
  .save_pc_o(save_pc_o), .cause_o(cause_o), .redir_vld_o(redir_vld_o),
  .redir_pc_o(redir_pc_o)
);

// File: tb/trapc_top_tb_top.sv
`timescale 1ns/1ps
module trapc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_req, mask_req, unmask_req, stat_wr, cause_wr;
  logic [4:0]  trap_vec;
  logic [31:0] pc, stat_wdata, cause_wdata;
  logic [31:0] stat_o, save_pc_o, save_stat_o, cause_o, redir_pc_o;
  logic        redir_vld_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] m_stat, m_spc, m_sst, m_cause, m_rpc;
  logic        m_rv;

  always #10 clk = ~clk;

  trapc_top dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_vec_i(trap_vec),
    .pc_i(pc), .mask_req_i(mask_req), .unmask_req_i(unmask_req),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .cause_wr_i(cause_wr),
    .cause_wdata_i(cause_wdata), .stat_o(stat_o), .save_pc_o(save_pc_o),
    .save_stat_o(save_stat_o), .cause_o(cause_o), .redir_vld_o(redir_vld_o),
    .redir_pc_o(redir_pc_o)
  );

  function automatic logic [31:0] handler(input logic [4:0] v);
    return (v < 5'd16) ? 32'h40 : 32'h50;
  endfunction

  // reference model: one sampling edge
  task automatic model_edge();
    logic taken;
    taken = trap_req && (trap_vec != 5'd31);
    m_rv = taken;
    if (taken) begin
      m_spc   = pc + 32'd4;
      m_sst   = m_stat;
      m_cause = {m_cause[31:16], 16'h0040 + {11'd0, trap_vec}};
      m_rpc   = handler(trap_vec);
      m_stat  = m_stat | 32'h60;
    end else begin
      if (cause_wr) m_cause = cause_wdata;
      if (mask_req)        m_stat = m_stat | 32'h20;
      else if (unmask_req) m_stat = m_stat & ~32'h20;
      else if (stat_wr)    m_stat = stat_wdata;
    end
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "stat", stat_o, m_stat);
    cmp(tag, "save_pc", save_pc_o, m_spc);
    cmp(tag, "save_stat", save_stat_o, m_sst);
    cmp(tag, "cause", cause_o, m_cause);
    cmp(tag, "redir_vld", {31'd0, redir_vld_o}, {31'd0, m_rv});
    cmp(tag, "redir_pc", redir_pc_o, m_rpc);
  endtask

  task automatic idle();
    trap_req = 0; mask_req = 0; unmask_req = 0; stat_wr = 0; cause_wr = 0;
    trap_vec = '0; pc = '0; stat_wdata = '0; cause_wdata = '0;
  endtask

  // inputs already set at negedge; take one edge, then check at next negedge
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
    idle();
  endtask

  task automatic trap(input logic [4:0] v, input logic [31:0] p, input string tag);
    trap_req = 1; trap_vec = v; pc = p;
    step(tag);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst_n = 0;
    m_stat = 0; m_spc = 0; m_sst = 0; m_cause = 0; m_rpc = 0; m_rv = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    stat_wr = 1; stat_wdata = 32'h0000_0011; step("R10");
    cause_wr = 1; cause_wdata = 32'hABCD_1234; step("R10");
    trap(5'd0, 32'h0000_1000, "R2");
    step("R6");
    trap(5'd15, 32'h0000_2000, "R3");
    trap(5'd16, 32'h0000_3000, "R4");
    trap(5'd30, 32'hFFFF_FFFC, "R5");
    unmask_req = 1; step("R7");
    mask_req = 1; step("R7");
    unmask_req = 1; step("R7");
    trap(5'd31, 32'h0000_4000, "R8");
    trap_req = 1; trap_vec = 5'd31; mask_req = 1; cause_wr = 1;
    cause_wdata = 32'h5555_0000; step("R8");
    trap_req = 1; trap_vec = 5'd7; pc = 32'h100; mask_req = 1; unmask_req = 1;
    stat_wr = 1; stat_wdata = 32'hFFFF_FFFF; cause_wr = 1; cause_wdata = 32'h1; step("R9");
    unmask_req = 1; step("R9");
    mask_req = 1; unmask_req = 1; step("R9");
    unmask_req = 1; stat_wr = 1; stat_wdata = 32'h0; step("R9");

    for (int i = 0; i < 2000; i++) begin
      int sel;
      trap_req   = ($urandom_range(9) < 3);
      sel = $urandom_range(7);
      trap_vec   = (sel == 0) ? 5'd31 : (sel == 1) ? 5'd15 : (sel == 2) ? 5'd16 :
                   (sel == 3) ? 5'd30 : 5'($urandom);
      pc         = $urandom & 32'hFFFF_FFFC;
      mask_req   = ($urandom_range(9) < 2);
      unmask_req = ($urandom_range(9) < 2);
      stat_wr    = ($urandom_range(9) == 0);
      stat_wdata = $urandom;
      cause_wr   = ($urandom_range(9) == 0);
      cause_wdata = $urandom;
      step("R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule